// File: doc/BRIEF.md
# DQ-Reference to PWM Compare Count Converter

This block turns a voltage command, given in the rotating d/q frame, into three compare counts for a carrier-based PWM modulator. Each sample carries the d and q voltage references, the sine and cosine of the grid angle, the measured DC bus voltage and the carrier period in modulator ticks (one tick is 4 ns). The block rotates the command back to the stationary alpha/beta frame, splits it into three phase voltages, and divides each phase voltage by the bus voltage. It then adds a half-scale offset, clamps the fraction to the unit interval and multiplies by the carrier period. The result is an unsigned 16-bit count per phase.

Samples enter and results leave over valid/ready handshakes. The block works on one sample at a time. `in_ready` is high only while the block is idle. A sample is taken on a clock edge where `in_valid` and `in_ready` are both high, and every field of it (bus voltage and carrier period included) is captured at that edge. The three counts and the bus-fault flag are shown together under one `out_valid`. When `out_ready` is low the results hold steady, and no new sample is accepted until the result has been taken. The bus voltage is a plain unsigned number in the same units as the voltage references, so only the ratio between them matters. Sine and cosine are signed with 14 fraction bits (16384 means 1.0).

Top module: `dq_duty_calc`

## Requirements
- R1: `in_ready` is 1 only when no sample is in flight and no result is pending. A sample is captured on an edge where `in_valid` and `in_ready` are both 1. While busy, `in_valid` has no effect, and the result reflects the input values present at the capture edge.
- R2: The rotation to the stationary frame is alpha = floor((vd*cos - vq*sin) / 2^14) and beta = floor((vd*sin + vq*cos) / 2^14).
- R3: The phase voltages are Ea = alpha, Eb = -floor(alpha/2) + floor(beta*14189 / 2^14) and Ec = -floor(alpha/2) - floor(beta*14189 / 2^14).
- R4: With S = 2E + Vdc and Vdc > 0, a phase whose S lies strictly between 0 and 2*Vdc gets the count floor(S*P / (2*Vdc)), where P is the carrier period in ticks.
- R5: A phase with S <= 0 gets count 0. A phase with S >= 2*Vdc gets count P. No count ever exceeds P.
- R6: When Vdc is 0, all three counts are floor(P/2) and `bus_fault` is 1. When Vdc is nonzero, `bus_fault` is 0.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, the three counts and `bus_fault` stay unchanged. The result is consumed on an edge where both are 1, and `out_valid` is 0 after that edge.
- R8: After reset, `in_ready` is 1, `out_valid` is 0, and all counts and `bus_fault` are 0.
- R9: The carrier period is taken from each sample, so successive samples with different periods produce counts scaled by their own period, from 1 up to 65535.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample valid |
| in_ready | output | 1 | Block can accept a sample |
| v_d | input | 16 | Signed d-axis voltage reference |
| v_q | input | 16 | Signed q-axis voltage reference |
| ang_sin | input | 16 | Signed sine of grid angle, 14 fraction bits |
| ang_cos | input | 16 | Signed cosine of grid angle, 14 fraction bits |
| v_bus | input | 16 | Unsigned DC bus voltage |
| car_period | input | 16 | Carrier period in ticks |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream takes the result |
| cmp_a | output | 16 | Phase A compare count |
| cmp_b | output | 16 | Phase B compare count |
| cmp_c | output | 16 | Phase C compare count |
| bus_fault | output | 1 | Bus voltage was zero for this result |

## Verification
The sweep covers full-scale positive and negative references at eight angles, so some phases clamp to 0 and others to P. A design that let the offset fraction wrap would show small or huge counts where the bench expects the rails. A zero bus voltage is mixed with tiny and large ones. A divider without the zero guard would produce an all-ones quotient rather than the midpoint, and it would leave the fault flag clear. Periods of 1 and 65535 catch truncation of the scaled product. Garbage values are held on the input with `in_valid` high while a sample is in flight, and the result is held back for several cycles. This exposes a design that re-captures its inputs or lets the result drift under back-pressure.

// File: rtl/dqd_pkg.sv
package dqd_pkg;
  localparam int TFRAC = 14;
  // sqrt(3)/2 scaled by 2^TFRAC, rounded
  localparam int SQ3H = int'(0.8660254037844386 * real'(1 << TFRAC) + 0.5);

  typedef enum logic [2:0] {
    ST_IDLE, ST_PARK, ST_CLARKE, ST_NORM, ST_DIV, ST_OUT
  } dqd_state_t;

  typedef enum logic [1:0] {
    SEL_MID, SEL_LO, SEL_HI
  } dqd_sel_t;
endpackage

// File: rtl/dqd_inv_park.sv
module dqd_inv_park #(
  parameter int VW = 16,
  parameter int TW = 16,
  parameter int AW = 19
) (
  input  logic signed [VW-1:0] vd,
  input  logic signed [VW-1:0] vq,
  input  logic signed [TW-1:0] sn,
  input  logic signed [TW-1:0] cs,
  output logic signed [AW-1:0] alpha,
  output logic signed [AW-1:0] beta
);
  localparam int PWD = VW + TW + 1;

  logic signed [PWD-1:0] acc_a, acc_b, sh_a, sh_b;

  always_comb begin
    acc_a = PWD'(vd * cs) - PWD'(vq * sn);
    acc_b = PWD'(vd * sn) + PWD'(vq * cs);
    sh_a  = acc_a >>> dqd_pkg::TFRAC;
    sh_b  = acc_b >>> dqd_pkg::TFRAC;
    alpha = sh_a[AW-1:0];
    beta  = sh_b[AW-1:0];
  end
endmodule

// File: rtl/dqd_inv_clarke.sv
module dqd_inv_clarke #(
  parameter int AW = 19,
  parameter int EW = 21
) (
  input  logic signed [AW-1:0] alpha,
  input  logic signed [AW-1:0] beta,
  output logic signed [EW-1:0] ph [3]
);
  localparam int KW  = dqd_pkg::TFRAC + 2;
  localparam int MW  = AW + KW;
  localparam logic signed [KW-1:0] K = KW'(dqd_pkg::SQ3H);

  logic signed [MW-1:0] prod, kb;
  logic signed [EW-1:0] half, kbe;

  always_comb begin
    prod  = MW'(beta) * MW'(K);
    kb    = prod >>> dqd_pkg::TFRAC;
    kbe   = kb[EW-1:0];
    half  = EW'(alpha) >>> 1;
    ph[0] = EW'(alpha);
    ph[1] = kbe - half;
    ph[2] = -half - kbe;
  end
endmodule

// File: rtl/dqd_divider.sv
module dqd_divider #(
  parameter int NW = 33,
  parameter int DW = 17,
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic [QW-1:0] quo,
  output logic          done
);
  localparam int CW = $clog2(QW + 1);

  logic [NW-1:0] rem, dsh;
  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem  <= '0;
      dsh  <= '0;
      quo  <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem <= num;
        dsh <= NW'(den) << (QW - 1);
        quo <= '0;
        cnt <= CW'(QW);
        run <= 1'b1;
      end else if (run) begin
        if (rem >= dsh) begin
          rem <= rem - dsh;
          quo <= {quo[QW-2:0], 1'b1};
        end else begin
          quo <= {quo[QW-2:0], 1'b0};
        end
        dsh <= dsh >> 1;
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dq_duty_calc.sv
module dq_duty_calc #(
  parameter int VW = 16,
  parameter int TW = 16,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [VW-1:0] v_d,
  input  logic [VW-1:0] v_q,
  input  logic [TW-1:0] ang_sin,
  input  logic [TW-1:0] ang_cos,
  input  logic [VW-1:0] v_bus,
  input  logic [PW-1:0] car_period,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] cmp_a,
  output logic [PW-1:0] cmp_b,
  output logic [PW-1:0] cmp_c,
  output logic          bus_fault
);
  import dqd_pkg::*;

  localparam int AW = VW + 3;
  localparam int EW = AW + 2;
  localparam int SW = EW + 2;
  localparam int DW = VW + 1;
  localparam int NW = DW + PW;

  dqd_state_t state;

  logic signed [VW-1:0] vd_q, vq_q;
  logic signed [TW-1:0] sn_q, cs_q;
  logic [VW-1:0]        vdc_q;
  logic [PW-1:0]        per_q;
  logic signed [AW-1:0] al_c, be_c, al_q, be_q;
  logic signed [EW-1:0] ph_c [3];
  logic signed [EW-1:0] ph_q [3];
  logic [PW-1:0]        cmp_q [3];
  logic                 err_q;
  logic                 div_done [3];
  logic [PW-1:0]        div_quo [3];
  dqd_sel_t             sel_q [3];
  logic [DW-1:0]        den;
  logic                 take;

  assign take     = in_valid && in_ready;
  assign in_ready = (state == ST_IDLE);
  assign out_valid = (state == ST_OUT);
  assign den      = {vdc_q, 1'b0};

  dqd_inv_park #(.VW(VW), .TW(TW), .AW(AW)) park_i (
    .vd(vd_q), .vq(vq_q), .sn(sn_q), .cs(cs_q), .alpha(al_c), .beta(be_c)
  );

  dqd_inv_clarke #(.AW(AW), .EW(EW)) clarke_i (
    .alpha(al_q), .beta(be_q), .ph(ph_c)
  );

  for (genvar g = 0; g < 3; g++) begin : g_phase
    logic signed [SW-1:0] s_c, lim_c;
    logic [NW-1:0]        num_c;
    dqd_sel_t             sel_c;

    always_comb begin
      s_c   = (SW'(ph_q[g]) <<< 1) + $signed(SW'(vdc_q));
      lim_c = $signed(SW'(den));
      num_c = '0;
      if (s_c <= 0)          sel_c = SEL_LO;
      else if (s_c >= lim_c) sel_c = SEL_HI;
      else begin
        sel_c = SEL_MID;
        num_c = NW'(s_c[DW-1:0]) * NW'(per_q);
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                 sel_q[g] <= SEL_MID;
      else if (state == ST_NORM)  sel_q[g] <= sel_c;
    end

    dqd_divider #(.NW(NW), .DW(DW), .QW(PW)) div_i (
      .clk(clk), .rst_n(rst_n), .start(state == ST_NORM),
      .num(num_c), .den(den), .quo(div_quo[g]), .done(div_done[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      vd_q  <= '0;
      vq_q  <= '0;
      sn_q  <= '0;
      cs_q  <= '0;
      vdc_q <= '0;
      per_q <= '0;
      al_q  <= '0;
      be_q  <= '0;
      err_q <= 1'b0;
      for (int i = 0; i < 3; i++) begin
        ph_q[i]  <= '0;
        cmp_q[i] <= '0;
      end
    end else begin
      case (state)
        ST_IDLE: if (take) begin
          vd_q  <= $signed(v_d);
          vq_q  <= $signed(v_q);
          sn_q  <= $signed(ang_sin);
          cs_q  <= $signed(ang_cos);
          vdc_q <= v_bus;
          per_q <= car_period;
          state <= ST_PARK;
        end
        ST_PARK: begin
          al_q  <= al_c;
          be_q  <= be_c;
          state <= ST_CLARKE;
        end
        ST_CLARKE: begin
          for (int i = 0; i < 3; i++) ph_q[i] <= ph_c[i];
          state <= ST_NORM;
        end
        ST_NORM: state <= ST_DIV;
        ST_DIV: if (div_done[0]) begin
          err_q <= (vdc_q == '0);
          for (int i = 0; i < 3; i++) begin
            if (vdc_q == '0)            cmp_q[i] <= per_q >> 1;
            else if (sel_q[i] == SEL_LO) cmp_q[i] <= '0;
            else if (sel_q[i] == SEL_HI) cmp_q[i] <= per_q;
            else                         cmp_q[i] <= div_quo[i];
          end
          state <= ST_OUT;
        end
        ST_OUT: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmp_a     = cmp_q[0];
  assign cmp_b     = cmp_q[1];
  assign cmp_c     = cmp_q[2];
  assign bus_fault = err_q;
endmodule

// File: rtl/dq_duty_calc_chk.sv
module dq_duty_calc_chk #(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [PW-1:0] cmp_a,
  input logic [PW-1:0] cmp_b,
  input logic [PW-1:0] cmp_c,
  input logic          bus_fault,
  input logic [PW-1:0] per_q
);
  p_ready_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (cmp_a <= per_q && cmp_b <= per_q && cmp_c <= per_q));

  p_fault_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && bus_fault) |-> (cmp_a == cmp_b && cmp_b == cmp_c));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(cmp_a) && $stable(cmp_b)
                                   && $stable(cmp_c) && $stable(bus_fault)));

  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);
endmodule

bind dq_duty_calc dq_duty_calc_chk #(.PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .cmp_a(cmp_a), .cmp_b(cmp_b),
  .cmp_c(cmp_c), .bus_fault(bus_fault), .per_q(per_q)
);

// File: tb/dq_duty_calc_tb_top.sv
`timescale 1ns/1ps
module dq_duty_calc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] v_d = '0, v_q = '0, ang_sin = '0, ang_cos = '0, v_bus = '0, car_period = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] cmp_a, cmp_b, cmp_c;
  logic        bus_fault;

  int vecs = 0;
  int miss = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  dq_duty_calc dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .v_d(v_d), .v_q(v_q), .ang_sin(ang_sin), .ang_cos(ang_cos),
    .v_bus(v_bus), .car_period(car_period), .out_valid(out_valid),
    .out_ready(out_ready), .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c),
    .bus_fault(bus_fault)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    vecs++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R4/R5/R6 duty rule
  function automatic longint duty_of(longint e, longint vdc, longint p);
    longint s;
    if (vdc == 0) return p / 2;
    s = 2 * e + vdc;
    if (s <= 0) return 0;
    if (s >= 2 * vdc) return p;
    return (s * p) / (2 * vdc);
  endfunction

  task automatic run_vec(input longint vd, input longint vq, input longint sn,
                         input longint cs, input longint vdc, input longint p,
                         input int hold);
    longint al, be, hf, kb;
    longint ex [3];
    logic [15:0] ha, hb, hc;
    int n;
    // R2 / R3 expected values
    al = (vd * cs - vq * sn) >>> 14;
    be = (vd * sn + vq * cs) >>> 14;
    hf = al >>> 1;
    kb = (be * 14189) >>> 14;
    ex[0] = duty_of(al, vdc, p);
    ex[1] = duty_of(kb - hf, vdc, p);
    ex[2] = duty_of(-hf - kb, vdc, p);

    @(negedge clk);
    chk("R1 ready when idle", in_ready, 1);
    in_valid = 1'b1;
    v_d = 16'(vd); v_q = 16'(vq); ang_sin = 16'(sn); ang_cos = 16'(cs);
    v_bus = 16'(vdc); car_period = 16'(p);
    @(negedge clk);
    chk("R1 busy after capture", in_ready, 0);
    // garbage while busy must not be captured (R1)
    v_d = 16'h7abc; v_q = 16'h8123; ang_sin = 16'h1111; v_bus = 16'd3; car_period = 16'd77;
    n = 0;
    while (!out_valid && n < 100) begin
      @(negedge clk);
      n++;
    end
    in_valid = 1'b0;
    if (!out_valid) chk("R1 result timeout", 0, 1);
    chk("R2 R3 R4 R5 R9 phase a", cmp_a, ex[0]);
    chk("R2 R3 R4 R5 R9 phase b", cmp_b, ex[1]);
    chk("R2 R3 R4 R5 R9 phase c", cmp_c, ex[2]);
    chk("R6 bus fault flag", bus_fault, (vdc == 0) ? 1 : 0);
    ha = cmp_a; hb = cmp_b; hc = cmp_c;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R7 valid held", out_valid, 1);
      chk("R7 count held", {cmp_a, cmp_b, cmp_c}, {ha, hb, hc});
      chk("R7 no accept while pending", in_ready, 0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R7 drained", out_valid, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      miss++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    longint vds [6] = '{-32768, -600, 0, 300, 800, 32767};
    longint vqs [3] = '{-400, 0, 500};
    longint vbs [4] = '{0, 7, 400, 750};
    longint pers [4] = '{1, 500, 1000, 65535};
    int idx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R8 reset in_ready", in_ready, 1);
    chk("R8 reset out_valid", out_valid, 0);
    chk("R8 reset counts", {cmp_a, cmp_b, cmp_c}, 0);
    chk("R8 reset fault", bus_fault, 0);
    for (int a = 0; a < 8; a++) begin
      real ang;
      longint sn, cs;
      ang = 3.14159265358979 * real'(a) / 4.0;
      sn = longint'($floor($sin(ang) * 16384.0 + 0.5));
      cs = longint'($floor($cos(ang) * 16384.0 + 0.5));
      foreach (vds[i]) foreach (vqs[j]) foreach (vbs[k]) foreach (pers[m]) begin
        run_vec(vds[i], vqs[j], sn, cs, vbs[k], pers[m], idx % 4);
        idx++;
      end
    end
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule